// File: doc/BRIEF.md
# Indexed Block Configuration Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C signalling, clock line driven by the host, data line open-drain). It gives the host block access to a small file of byte-wide configuration registers. A write transaction carries three things in turn: a starting register index, a byte count, and then the data bytes. The data bytes go to consecutive registers.

A read transaction first sets the index with a short write phase and then turns the bus round with a repeated start. The target sends a count byte first. After that it sends register bytes from the index upward for as long as the host acknowledges. The count byte is kept in a register inside the block. The host can rewrite that register through an ordinary write transaction.

The register file itself sits outside the block. The block drives a write strobe with an index and data, and a combinational read index for it. Bus lines are synchronised and oversampled on the system clock. Start and stop conditions are SDA edges seen while SCL is high. `xfer_done` marks the end of each transaction that addressed this target.

Controller states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: receiving the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_IDX`: receiving the index.
- `ST_IDX_ACK`: acknowledging the index.
- `ST_CNT`: receiving the count.
- `ST_CNT_ACK`: acknowledging the count.
- `ST_WDAT`: receiving a data byte.
- `ST_WDAT_ACK`: acknowledging a data byte.
- `ST_TX`: shifting a byte out.
- `ST_TX_ACK`: sampling the host's acknowledge.
- `ST_HOLD`: ignoring the bus until the next start or stop.

Transitions:
- A stop in any state leads to `ST_IDLE`. A start in any state leads to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match and to `ST_HOLD` otherwise.
- `ST_ADDR_ACK` goes to `ST_TX` for a read and to `ST_IDX` for a write.
- `ST_IDX` goes to `ST_IDX_ACK` for an index in range and to `ST_HOLD` otherwise.
- `ST_IDX_ACK` goes to `ST_CNT`, then `ST_CNT_ACK`, then `ST_WDAT`.
- `ST_WDAT` goes to `ST_WDAT_ACK` while count remains, then back to `ST_WDAT`. It goes to `ST_HOLD` once the count is spent.
- `ST_TX` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes back to `ST_TX` on a host ACK and to `ST_HOLD` on a NACK.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target acknowledges only address bytes whose upper seven bits equal DEV_ADDR (default 7'h69, so D2h writes and D3h reads; bit 0 is 1 for read). Any other address is not acknowledged, and the target ignores the bus until the next start or stop.
- R2: A write transaction (address D2h, index N, count X, data) acknowledges every byte. Each data byte is written to the register file with exactly one `wr_en` pulse, at indices N, N+1, and so on.
- R3: An index byte of NUM_REGS or above is not acknowledged, and no register is written in that transaction.
- R4: A count of 0 is acknowledged and writes nothing. Data bytes beyond the count are not acknowledged and are not written.
- R5: The index advances by one after each data byte written or read. It wraps from NUM_REGS-1 to 0.
- R6: After the index phase, a repeated start and address D3h, the target sends the count register first. It then sends register contents starting at index N, one byte per host acknowledge.
- R7: After the host answers a read byte with NACK, the target stops driving SDA until the next start or stop.
- R8: The readback count register sits at index CNT_IDX (default 8) and resets to 0Fh. Writes to it update it without a `wr_en` pulse. Reading it returns its value.
- R9: A stop or a start at any point, including inside a byte, abandons the transaction. A start begins a new address phase.
- R10: `sda_oe` changes only while SCL is low. It is 0 after reset.
- R11: `xfer_done` pulses for one cycle after a stop that ends a transaction which addressed this target. It stays low for foreign traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_idx | output | IDX_W | Register index for the write |
| wr_data | output | 8 | Register write data |
| rd_idx | output | IDX_W | Register index presented for reading |
| rd_data | input | 8 | Combinational read data for `rd_idx` |
| xfer_done | output | 1 | One-cycle pulse at the end of an addressed transaction |

## Verification
The hardest states to reach are those entered by stepping off the normal protocol: a data stream that runs past its declared count, an index wrap that falls in the middle of a read burst, a stop in the middle of a byte, and the released bus after a host NACK. Directed bus sequences reach each of them. The bench sends surplus bytes and starts writes and reads near the top index. It cuts a byte after four bits with a stop. It clocks one more byte after a NACK and expects all ones on the line. Seeded random write-then-read pairs then cover other index, count and data mixes, including hits on the count register.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_IDX,
        ST_IDX_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } ctrl_st_e;

endpackage

// File: rtl/cfg_i2c_sync.sv
// Synchronises SCL and SDA and derives edge and bus-condition events.
module cfg_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prv;

    assign raw = {scl_in, sda_in};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            logic [STAGES-1:0] pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], raw[g]};
            end
            assign cur[g] = pipe[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prv <= '1;
        else        prv <= cur;
    end

    assign scl_s     = cur[1];
    assign sda_s     = cur[0];
    assign scl_rise  = cur[1] & ~prv[1];
    assign scl_fall  = ~cur[1] & prv[1];
    assign start_det = cur[1] & prv[1] & prv[0] & ~cur[0];
    assign stop_det  = cur[1] & prv[1] & ~prv[0] & cur[0];

endmodule

// File: rtl/cfg_i2c_shift.sv
// Shared byte shifter: samples on SCL rise when receiving, shifts on SCL fall when sending.
module cfg_i2c_shift
    import cfg_i2c_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  load,
    input  byte_t load_byte,
    input  logic  rx_en,
    input  logic  tx_en,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  sda_s,
    output byte_t shreg,
    output logic  bits_done,
    output logic  tx_bit
);

    localparam int CW = $clog2(BYTE_W) + 1;

    logic [CW-1:0] bcnt;

    assign bits_done = (bcnt == CW'(BYTE_W));
    assign tx_bit    = shreg[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (clr) begin
            bcnt  <= '0;
        end else if (load) begin
            shreg <= load_byte;
            bcnt  <= '0;
        end else if (rx_en && scl_rise && !bits_done) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            bcnt  <= bcnt + 1'b1;
        end else if (tx_en && scl_fall && !bits_done) begin
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
            bcnt  <= bcnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_i2c_ctrl.sv
// Transaction controller: protocol states, index pointer, count register, ACK drive.
module cfg_i2c_ctrl
    import cfg_i2c_pkg::*;
#(
    parameter int          NUM_REGS  = 24,
    parameter logic [6:0]  DEV_ADDR  = 7'h69,
    parameter int          CNT_IDX   = 8,
    parameter logic [7:0]  CNT_RESET = 8'h0F,
    localparam int         IDX_W     = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  byte_t            shreg,
    input  logic             bits_done,
    input  logic             tx_bit,
    input  byte_t            rd_data,
    output logic             shf_clr,
    output logic             shf_load,
    output byte_t            load_byte,
    output logic             rx_en,
    output logic             tx_en,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output byte_t            wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             xfer_done
);

    ctrl_st_e         state, nxt;
    logic [IDX_W-1:0] ptr;
    byte_t            remain;
    byte_t            cnt_q;
    logic             rw_q;
    logic             first_q;
    logic             engaged;
    logic             host_ack;
    logic             byte_in;
    logic             addr_hit;
    logic             idx_ok;
    logic             ptr_is_cnt;
    logic [IDX_W-1:0] ptr_inc;

    assign byte_in    = bits_done && scl_fall;
    assign addr_hit   = (shreg[7:1] == DEV_ADDR);
    assign idx_ok     = (int'(shreg) < NUM_REGS);
    assign ptr_is_cnt = (ptr == IDX_W'(CNT_IDX));
    assign ptr_inc    = (ptr == IDX_W'(NUM_REGS - 1)) ? '0 : ptr + 1'b1;

    // Next-state decode
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_HOLD:     nxt = ST_HOLD;
                ST_ADDR:     if (byte_in) nxt = addr_hit ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_TX : ST_IDX;
                ST_IDX:      if (byte_in) nxt = idx_ok ? ST_IDX_ACK : ST_HOLD;
                ST_IDX_ACK:  if (scl_fall) nxt = ST_CNT;
                ST_CNT:      if (byte_in) nxt = ST_CNT_ACK;
                ST_CNT_ACK:  if (scl_fall) nxt = ST_WDAT;
                ST_WDAT:     if (byte_in) nxt = (remain != '0) ? ST_WDAT_ACK : ST_HOLD;
                ST_WDAT_ACK: if (scl_fall) nxt = ST_WDAT;
                ST_TX:       if (bits_done) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) nxt = host_ack ? ST_TX : ST_HOLD;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Output and shifter control decode
    always_comb begin
        rx_en    = (state == ST_ADDR) || (state == ST_IDX) ||
                   (state == ST_CNT)  || (state == ST_WDAT);
        tx_en    = (state == ST_TX);
        sda_oe   = (state == ST_ADDR_ACK) || (state == ST_IDX_ACK) ||
                   (state == ST_CNT_ACK)  || (state == ST_WDAT_ACK) ||
                   ((state == ST_TX) && !bits_done && !tx_bit);
        shf_load = (nxt == ST_TX) && (state != ST_TX);
        shf_clr  = start_det ||
                   ((nxt != state) && ((nxt == ST_ADDR) || (nxt == ST_IDX) ||
                                       (nxt == ST_CNT)  || (nxt == ST_WDAT)));
        load_byte = (first_q || ptr_is_cnt) ? cnt_q : rd_data;
    end

    assign rd_idx = ptr;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            remain    <= '0;
            cnt_q     <= CNT_RESET;
            rw_q      <= 1'b0;
            first_q   <= 1'b0;
            engaged   <= 1'b0;
            host_ack  <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            xfer_done <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            xfer_done <= stop_det && engaged;
            if (stop_det) engaged <= 1'b0;
            if (state == ST_ADDR && nxt == ST_ADDR_ACK) begin
                rw_q    <= shreg[0];
                first_q <= 1'b1;
                engaged <= 1'b1;
            end
            if (state == ST_IDX && nxt == ST_IDX_ACK) ptr <= shreg[IDX_W-1:0];
            if (state == ST_CNT && nxt == ST_CNT_ACK) remain <= shreg;
            if (state == ST_WDAT && nxt == ST_WDAT_ACK) begin
                if (ptr_is_cnt) begin
                    cnt_q <= shreg;
                end else begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr;
                    wr_data <= shreg;
                end
                remain <= remain - 8'd1;
                ptr    <= ptr_inc;
            end
            if (shf_load) begin
                if (first_q) first_q <= 1'b0;
                else         ptr     <= ptr_inc;
            end
            if (state == ST_TX_ACK && scl_rise) host_ack <= ~sda_s;
        end
    end

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (sda_oe != $past(sda_oe)) |-> !scl_s); // R10
    AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> ($past(state) == ST_WDAT)); // R2
    AST_NO_WRITE_PAST_COUNT: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> ($past(remain) != '0)); // R4
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(ptr) < NUM_REGS); // R5
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $past(stop_det) |-> (state == ST_IDLE)); // R9
    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |-> $past(stop_det)); // R11

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int          NUM_REGS    = 24,
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter int          CNT_IDX     = 8,
    parameter logic [7:0]  CNT_RESET   = 8'h0F,
    parameter int          SYNC_STAGES = 2,
    localparam int         IDX_W       = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_data,
    output logic             xfer_done
);

    logic  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic  shf_clr, shf_load, rx_en, tx_en, bits_done, tx_bit;
    byte_t shreg, load_byte;

    cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_i2c_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (shf_clr),
        .load      (shf_load),
        .load_byte (load_byte),
        .rx_en     (rx_en),
        .tx_en     (tx_en),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .shreg     (shreg),
        .bits_done (bits_done),
        .tx_bit    (tx_bit)
    );

    cfg_i2c_ctrl #(
        .NUM_REGS  (NUM_REGS),
        .DEV_ADDR  (DEV_ADDR),
        .CNT_IDX   (CNT_IDX),
        .CNT_RESET (CNT_RESET)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .shreg     (shreg),
        .bits_done (bits_done),
        .tx_bit    (tx_bit),
        .rd_data   (rd_data),
        .shf_clr   (shf_clr),
        .shf_load  (shf_load),
        .load_byte (load_byte),
        .rx_en     (rx_en),
        .tx_en     (tx_en),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .xfer_done (xfer_done)
    );

endmodule

// File: tb/cfg_i2c_target_bench.sv
module cfg_i2c_target_bench;

    localparam int NREG = 24;
    localparam int IW   = 5;
    localparam int Q    = 6;
    localparam int CIDX = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe, wr_en, xfer_done, sda_ln;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [7:0] wr_data, rd_data;

    always #10 clk = ~clk;

    assign sda_ln  = sda_h & ~sda_oe;

    logic [7:0] mem     [NREG];
    logic [7:0] exp_mem [NREG];
    logic [7:0] exp_cnt;
    logic [7:0] wbuf    [16];
    logic [7:0] rbuf    [16];
    logic       ackv    [16];
    logic       ack_a, ack_i, ack_c, ack_r;
    logic [7:0] cnt_byte;
    int n_checks = 0, n_fail = 0;
    int wr_pulses = 0, done_cnt = 0, oe_bad = 0;
    logic oe_prev = 1'b0;
    bit  finished = 0;

    assign rd_data = mem[rd_idx];

    cfg_i2c_target u_cfg_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_ln),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .xfer_done(xfer_done)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
            wr_pulses = wr_pulses + 1;
        end
        if (xfer_done) done_cnt = done_cnt + 1;
    end

    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_h) oe_bad = oe_bad + 1;
        oe_prev = sda_oe;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; tick(Q); scl_h = 1'b1; tick(2 * Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        acked = !sda_ln; tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_h = 1'b1; tick(Q); b[i] = sda_ln; tick(Q); scl_h = 1'b0;
        end
        tick(1); sda_h = ~give_ack; tick(Q - 1);
        scl_h = 1'b1; tick(2 * Q); scl_h = 1'b0; tick(Q); sda_h = 1'b1;
    endtask

    function automatic int wrap_inc(input int idx);
        return (idx == NREG - 1) ? 0 : idx + 1;
    endfunction

    function automatic logic [7:0] exp_reg(input int idx);
        return (idx == CIDX) ? exp_cnt : exp_mem[idx];
    endfunction

    function automatic int mem_mismatch();
        int m = 0;
        for (int i = 0; i < NREG; i++) if (mem[i] !== exp_mem[i]) m++;
        return m;
    endfunction

    task automatic model_write(input int n, input int nb);
        int idx = n;
        for (int i = 0; i < nb; i++) begin
            if (idx == CIDX) exp_cnt = wbuf[i];
            else             exp_mem[idx] = wbuf[i];
            idx = wrap_inc(idx);
        end
    endtask

    task automatic do_write(input logic [7:0] addr, input int n, input int x, input int nsend);
        logic a;
        bus_start();
        send_byte(addr, a); ack_a = a;
        send_byte(8'(n), a); ack_i = a;
        send_byte(8'(x), a); ack_c = a;
        for (int i = 0; i < nsend; i++) begin
            send_byte(wbuf[i], a); ackv[i] = a;
        end
        bus_stop();
    endtask

    task automatic do_read(input int n, input int k);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a); ack_a = a;
        send_byte(8'(n), a); ack_i = a;
        bus_start();
        send_byte(8'hD3, a); ack_r = a;
        recv_byte(k > 0, b); cnt_byte = b;
        for (int i = 0; i < k; i++) begin
            recv_byte(i < k - 1, b); rbuf[i] = b;
        end
        bus_stop();
    endtask

    task automatic read_and_check(input string req, input int n, input int k);
        int idx = n;
        int bad = 0;
        do_read(n, k);
        check(req, "read address ack", int'(ack_r), 1);
        check("R8", "count byte", int'(cnt_byte), int'(exp_cnt));
        for (int i = 0; i < k; i++) begin
            if (rbuf[i] !== exp_reg(idx)) bad++;
            idx = wrap_inc(idx);
        end
        check(req, "read data mismatches", bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w0, d0, n, x;
        logic a;
        logic [7:0] b;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) begin
            mem[i] = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        exp_cnt = 8'h0F;
        tick(5); rst_n = 1'b1; tick(5);

        // Reset state: R10, R11
        check("R10", "sda_oe after reset", int'(sda_oe), 0);
        check("R11", "xfer_done after reset", int'(xfer_done), 0);
        check("R2", "wr_en after reset", int'(wr_en), 0);

        // R8: default count value through a read
        read_and_check("R6", 0, 2);

        // R2 / R11: directed write of three bytes at index 2
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        w0 = wr_pulses; d0 = done_cnt;
        do_write(8'hD2, 2, 3, 3); tick(4);
        model_write(2, 3);
        check("R1", "write address ack", int'(ack_a), 1);
        check("R2", "index/count acks", int'(ack_i & ack_c), 1);
        check("R2", "data acks", int'(ackv[0] & ackv[1] & ackv[2]), 1);
        check("R2", "write pulses", wr_pulses - w0, 3);
        check("R2", "register contents", mem_mismatch(), 0);
        check("R11", "done pulses", done_cnt - d0, 1);
        read_and_check("R6", 2, 3);

        // R5: wrap from top index for write and read
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        do_write(8'hD2, NREG - 2, 4, 4); tick(4);
        model_write(NREG - 2, 4);
        check("R5", "wrapped contents", mem_mismatch(), 0);
        check("R5", "mem[0] after wrap", int'(mem[0]), 8'h33);
        read_and_check("R5", NREG - 1, 3);

        // R8: count register write has no strobe
        wbuf[0] = 8'h05;
        w0 = wr_pulses;
        do_write(8'hD2, CIDX, 1, 1); tick(4);
        model_write(CIDX, 1);
        check("R8", "no strobe for count reg", wr_pulses - w0, 0);
        read_and_check("R8", CIDX - 1, 3);

        // R4: zero count and surplus bytes
        wbuf[0] = 8'h99;
        w0 = wr_pulses;
        do_write(8'hD2, 3, 0, 1); tick(4);
        check("R4", "zero count acked", int'(ack_c), 1);
        check("R4", "surplus byte nacked", int'(ackv[0]), 0);
        check("R4", "zero count no write", wr_pulses - w0, 0);
        wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
        w0 = wr_pulses;
        do_write(8'hD2, 4, 1, 2); tick(4);
        model_write(4, 1);
        check("R4", "byte within count acked", int'(ackv[0]), 1);
        check("R4", "byte past count nacked", int'(ackv[1]), 0);
        check("R4", "one write only", wr_pulses - w0, 1);
        check("R4", "contents after surplus", mem_mismatch(), 0);

        // R3: index out of range
        wbuf[0] = 8'h77;
        w0 = wr_pulses;
        do_write(8'hD2, 30, 1, 1); tick(4);
        check("R3", "bad index nacked", int'(ack_i), 0);
        check("R3", "no write on bad index", wr_pulses - w0, 0);

        // R1 / R11: foreign address
        d0 = done_cnt; w0 = wr_pulses;
        wbuf[0] = 8'h66;
        do_write(8'hA0, 1, 1, 1); tick(4);
        check("R1", "foreign address nacked", int'(ack_a), 0);
        check("R1", "foreign index ignored", int'(ack_i), 0);
        check("R1", "foreign no write", wr_pulses - w0, 0);
        check("R11", "no done for foreign", done_cnt - d0, 0);

        // R9: stop in the middle of a byte, then a fresh write
        bus_start();
        send_byte(8'hD2, a); send_byte(8'd10, a); send_byte(8'd3, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop(); tick(4);
        check("R9", "aborted byte not written", mem_mismatch(), 0);
        wbuf[0] = 8'hE7;
        do_write(8'hD2, 12, 1, 1); tick(4);
        model_write(12, 1);
        check("R9", "write after abort acked", int'(ack_a & ack_i & ack_c & ackv[0]), 1);
        check("R9", "write after abort contents", mem_mismatch(), 0);

        // R7: after host NACK the target leaves SDA released
        bus_start();
        send_byte(8'hD2, a); send_byte(8'd6, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, b);
        recv_byte(1'b0, b);
        check("R7", "last byte before nack", int'(b), int'(exp_reg(6)));
        recv_byte(1'b0, b);
        check("R7", "line released after nack", int'(b), 8'hFF);
        bus_stop(); tick(4);

        // Random write/read pairs: R2, R5, R6
        for (int t = 0; t < 6; t++) begin
            n = $urandom_range(0, NREG - 1);
            x = $urandom_range(1, 5);
            for (int i = 0; i < x; i++) wbuf[i] = 8'($urandom);
            do_write(8'hD2, n, x, x); tick(4);
            model_write(n, x);
            check("R2", "random write acks", int'(ack_a & ack_i & ack_c & ackv[x-1]), 1);
            check("R2", "random contents", mem_mismatch(), 0);
            read_and_check("R6", n, x);
        end

        check("R10", "sda_oe moves with SCL high", oe_bad, 0);
        finish_run();
    end

endmodule